// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block turns three supply comparator flags into the digital actions a processor needs when its supply sags. Each flag is high while the supply sits below one of three ordered trip levels: the early-warning level, the minimum operating level and the battery switch-over level. The flags come from analog comparators and may change at any time, so the block synchronizes them before acting on them.

Crossing the warning level raises a one-cycle interrupt request carrying a fixed vector address. Processor operation carries on unchanged. Falling below the minimum operating level holds the processor in reset and pulls a shared open-drain reset line low. Falling below the battery level drives an active-low battery flag.

The shared reset line works in both directions. Any device pulling it low puts this block's processor into reset, which lets several supervisors bring their parts down together. Once every reset cause has cleared, the reset is held for a programmable power-on delay before it is released.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: When `warn_irq_en` is 1 and the synchronized warning flag goes from 0 to 1, `pfi_req` is 1 for exactly one cycle. In that cycle `pfi_vector` equals `IRQ_VECTOR` (default 8'h2B). While `pfi_req` is 0, `pfi_vector` is 8'h00.
- R2: The warning flag alone never asserts `cpu_rst` and never drives `rst_pin_oe`.
- R3: While the synchronized minimum-level flag is 1, `rst_pin_oe` is 1, and `cpu_rst` is 1 from the following cycle on.
- R4: A warning request is raised once per rising edge of the warning flag. No further request is raised while the flag stays high. No request is raised for an edge that occurs while `warn_irq_en` is 0.
- R5: A low level on `rst_pin_in` forces `cpu_rst` to 1, even when the block is not driving the line itself. The block's own release of the line does not hold it in reset forever.
- R6: After every reset cause clears (minimum-level flag low and reset line high, both as seen after synchronization), `cpu_rst` stays 1 for exactly `POR_CYCLES` more clock cycles and then falls. After `rst_n` is released with no cause present, `cpu_rst` falls on the `POR_CYCLES`-th rising edge.
- R7: If a reset cause returns while the power-on delay is counting, the count starts again from zero. The full delay then applies after the cause clears.
- R8: `bat_n` is 0 while the synchronized battery flag is 1, and 1 otherwise.
- R9: Each comparator flag, and the sensed reset line, passes through a `SYNC_STAGES`-deep synchronizer (default 2). With the default depth, a flag change made before clock edge E first shows on the combinational outputs `rst_pin_oe` and `bat_n` after edge E+1.
- R10: While `rst_n` is 0, the outputs are `cpu_rst`=1, `rst_pin_oe`=0, `bat_n`=1 and `pfi_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warn_below | input | 1 | Comparator: supply below warning level (asynchronous) |
| vmin_below | input | 1 | Comparator: supply below minimum operating level (asynchronous) |
| vbat_below | input | 1 | Comparator: supply below battery switch-over level (asynchronous) |
| warn_irq_en | input | 1 | Enables the warning interrupt request |
| rst_pin_in | input | 1 | Sensed level of the shared open-drain reset line |
| rst_pin_oe | output | 1 | 1 = pull the shared reset line low |
| cpu_rst | output | 1 | Active-high processor reset |
| pfi_req | output | 1 | One-cycle power-fail warning interrupt request |
| pfi_vector | output | 8 | Interrupt vector address, valid with `pfi_req` |
| bat_n | output | 1 | Low while running from the battery |

## Verification
The bench builds the block with `POR_CYCLES` set to 24 and the default two-stage synchronizers. The short delay lets the test see the exact cycle in which `cpu_rst` falls after `rst_n`, after a minimum-level release and after an external pull on the line. It also lets the test reassert a cause part-way through a count and still finish quickly. Keeping the synchronizer depth at its default fixes the cycle-by-cycle latencies that the directed checks sample, including the extra two cycles the line readback adds before a release starts counting.

// File: rtl/pfs_pkg.sv
// Package: shared types and constants of the power-fail supervisor.
// Assumes: the comparator flag bundle is synchronized as one vector.
package pfs_pkg;

    // Width of the interrupt vector address.
    localparam int VEC_W = 8;

    // One bundle of asynchronous condition flags, each high = condition present.
    typedef struct packed {
        logic warn;     // supply below warning level
        logic vmin;     // supply below minimum operating level
        logic vbat;     // supply below battery switch-over level
        logic pin_low;  // shared reset line sensed low
    } pfs_flags_t;

    localparam int FLAG_W = $bits(pfs_flags_t);

endpackage

// File: rtl/pfs_sync.sv
// Module: multi-bit flop-chain synchronizer.
// Does: carries each bit of an asynchronous vector through STAGES flops.
// Assumes: the bits are independent levels, so no cross-bit coherence is needed.
module pfs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    // Purpose: shift the input through the flop chain, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/pfs_warn_irq.sv
// Module: power-fail warning interrupt generator.
// Does: emits a one-cycle request with a fixed vector on each rising warning edge.
// Assumes: warn is already synchronized; edges seen while en=0 are dropped.
module pfs_warn_irq #(
    parameter int               VW     = 8,
    parameter logic [VW-1:0]    VECTOR = 8'h2B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warn,
    input  logic          en,
    output logic          req,
    output logic [VW-1:0] vector
);
    logic warn_q;

    // Purpose: remember last warning level and register the edge request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_q <= 1'b0;
            req    <= 1'b0;
        end else begin
            warn_q <= warn;
            req    <= warn & ~warn_q & en;
        end
    end

    // Purpose: present the vector only alongside the request.
    always_comb vector = req ? VECTOR : '0;
endmodule

// File: rtl/pfs_por_timer.sv
// Module: power-on reset delay timer.
// Does: holds busy while hold is high, then for POR_CYCLES further cycles.
// Assumes: hold is synchronous; comes out of rst_n counting a full delay.
module pfs_por_timer #(
    parameter int POR_CYCLES = 21504
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic busy
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Purpose: restart on hold, count while busy, drop busy at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (hold) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwr_fail_supervisor.sv
// Module: power-fail supervisor sequencer (top).
// Does: synchronizes three supply flags plus the shared reset line, raises the
//       warning interrupt, drives the open-drain reset line, times the
//       power-on delay and flags battery operation.
// Assumes: the line is drawn only while the minimum-level flag is present, so
//          its own release can never lock it in reset through the readback.
module pwr_fail_supervisor
    import pfs_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter int                  POR_CYCLES  = 21504,
    parameter logic [VEC_W-1:0]    IRQ_VECTOR  = 8'h2B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warn_below,
    input  logic             vmin_below,
    input  logic             vbat_below,
    input  logic             warn_irq_en,
    input  logic             rst_pin_in,
    output logic             rst_pin_oe,
    output logic             cpu_rst,
    output logic             pfi_req,
    output logic [VEC_W-1:0] pfi_vector,
    output logic             bat_n
);
    pfs_flags_t        raw_flags;
    pfs_flags_t        syn_flags;
    logic [FLAG_W-1:0] syn_bits;
    logic              hold;

    // Purpose: bundle the asynchronous conditions for the synchronizer.
    always_comb begin
        raw_flags.warn    = warn_below;
        raw_flags.vmin    = vmin_below;
        raw_flags.vbat    = vbat_below;
        raw_flags.pin_low = ~rst_pin_in;
    end

    pfs_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_flags),
        .q     (syn_bits)
    );

    assign syn_flags = pfs_flags_t'(syn_bits);

    // Purpose: derive the reset cause and the direct level outputs.
    always_comb begin
        hold       = syn_flags.vmin | syn_flags.pin_low;
        rst_pin_oe = syn_flags.vmin;
        bat_n      = ~syn_flags.vbat;
    end

    pfs_warn_irq #(.VW(VEC_W), .VECTOR(IRQ_VECTOR)) u_warn (
        .clk    (clk),
        .rst_n  (rst_n),
        .warn   (syn_flags.warn),
        .en     (warn_irq_en),
        .req    (pfi_req),
        .vector (pfi_vector)
    );

    pfs_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .busy  (cpu_rst)
    );
endmodule

// File: rtl/pwr_fail_supervisor_chk.sv
// Module: property checker bound to the supervisor top.
// Does: watches the ports for the sequencing rules; counts quiet cycles itself.
// Assumes: default synchronizer depth of two stages.
module pwr_fail_supervisor_chk #(
    parameter int         POR_CYCLES = 21504,
    parameter logic [7:0] IRQ_VECTOR = 8'h2B
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_pin_in,
    input logic       rst_pin_oe,
    input logic       cpu_rst,
    input logic       pfi_req,
    input logic [7:0] pfi_vector
);
    int unsigned cyc;
    int unsigned quiet;

    // Purpose: count cycles since reset and cycles with the line released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc   <= 0;
            quiet <= 0;
        end else begin
            if (cyc < 1000) cyc <= cyc + 1;
            if (rst_pin_in && !rst_pin_oe) begin
                if (quiet < POR_CYCLES + 8) quiet <= quiet + 1;
            end else begin
                quiet <= 0;
            end
        end
    end

    assert_oe_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_oe |=> cpu_rst);

    assert_pin_low_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3 && $past(!rst_pin_in, 3)) |-> cpu_rst);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pfi_req |=> !pfi_req);

    assert_vector_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pfi_req |-> (pfi_vector == IRQ_VECTOR));

    assert_por_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst) |-> (quiet >= POR_CYCLES - 1));
endmodule

bind pwr_fail_supervisor pwr_fail_supervisor_chk #(
    .POR_CYCLES (POR_CYCLES),
    .IRQ_VECTOR (IRQ_VECTOR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_pin_in (rst_pin_in),
    .rst_pin_oe (rst_pin_oe),
    .cpu_rst    (cpu_rst),
    .pfi_req    (pfi_req),
    .pfi_vector (pfi_vector)
);

// File: tb/pwr_fail_supervisor_tb.sv
module pwr_fail_supervisor_tb;
    localparam int POR = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warn_below = 1'b0;
    logic       vmin_below = 1'b0;
    logic       vbat_below = 1'b0;
    logic       warn_irq_en = 1'b1;
    logic       ext_pull = 1'b0;
    logic       rst_pin_in;
    logic       rst_pin_oe;
    logic       cpu_rst;
    logic       pfi_req;
    logic [7:0] pfi_vector;
    logic       bat_n;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    // open-drain line with pull-up
    assign rst_pin_in = ~(rst_pin_oe | ext_pull);

    pwr_fail_supervisor #(.SYNC_STAGES(2), .POR_CYCLES(POR), .IRQ_VECTOR(8'h2B)) u_dut (
        .clk(clk), .rst_n(rst_n), .warn_below(warn_below), .vmin_below(vmin_below),
        .vbat_below(vbat_below), .warn_irq_en(warn_irq_en), .rst_pin_in(rst_pin_in),
        .rst_pin_oe(rst_pin_oe), .cpu_rst(cpu_rst), .pfi_req(pfi_req),
        .pfi_vector(pfi_vector), .bat_n(bat_n)
    );

    typedef struct packed {
        logic warn; logic vmin; logic vbat; logic ext;
        logic e_rst; logic e_oe; logic e_bat_n;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(3);
        // R10: outputs while in reset
        chk("R10 cpu_rst", 8'(cpu_rst), 8'd1);
        chk("R10 oe", 8'(rst_pin_oe), 8'd0);
        chk("R10 bat_n", 8'(bat_n), 8'd1);
        chk("R10 pfi_req", 8'(pfi_req), 8'd0);

        // R6: power-on delay out of rst_n
        rst_n = 1'b1;
        tick(POR - 1);
        chk("R6 por still held", 8'(cpu_rst), 8'd1);
        tick(1);
        chk("R6 por released", 8'(cpu_rst), 8'd0);

        // steady-state table
        for (int i = 0; i < NV; i++) begin
            warn_below = TABLE[i].warn;
            vmin_below = TABLE[i].vmin;
            vbat_below = TABLE[i].vbat;
            ext_pull   = TABLE[i].ext;
            tick(POR + 8);
            chk("R2/R3/R5 table cpu_rst", 8'(cpu_rst), 8'(TABLE[i].e_rst));
            chk("R3 table oe", 8'(rst_pin_oe), 8'(TABLE[i].e_oe));
            chk("R8 table bat_n", 8'(bat_n), 8'(TABLE[i].e_bat_n));
        end

        // R1/R4: warning pulse timing, vector, no repeat
        warn_below = 1'b1;
        tick(2);
        chk("R1 no req yet", 8'(pfi_req), 8'd0);
        tick(1);
        chk("R1 req pulse", 8'(pfi_req), 8'd1);
        chk("R1 vector", pfi_vector, 8'h2B);
        chk("R2 no reset on warning", 8'(cpu_rst), 8'd0);
        tick(1);
        chk("R4 pulse ends", 8'(pfi_req), 8'd0);
        chk("R1 vector idle", pfi_vector, 8'h00);
        tick(10);
        chk("R4 no repeat while held", 8'(pfi_req), 8'd0);
        warn_below = 1'b0;
        tick(5);
        warn_below = 1'b1;
        tick(3);
        chk("R4 rearmed after clear", 8'(pfi_req), 8'd1);
        warn_below = 1'b0;
        tick(5);

        // R4: disabled edge produces nothing
        warn_irq_en = 1'b0;
        warn_below = 1'b1;
        tick(3);
        chk("R4 disabled no req", 8'(pfi_req), 8'd0);
        warn_irq_en = 1'b1;
        tick(4);
        chk("R4 late enable no req", 8'(pfi_req), 8'd0);
        warn_below = 1'b0;
        tick(5);

        // R9/R3: synchronizer latency on oe and bat_n
        vmin_below = 1'b1;
        vbat_below = 1'b1;
        tick(1);
        chk("R9 oe not yet", 8'(rst_pin_oe), 8'd0);
        chk("R9 bat_n not yet", 8'(bat_n), 8'd1);
        tick(1);
        chk("R9 oe after two", 8'(rst_pin_oe), 8'd1);
        chk("R8 bat_n low", 8'(bat_n), 8'd0);
        tick(1);
        chk("R3 cpu_rst follows", 8'(cpu_rst), 8'd1);
        vbat_below = 1'b0;
        tick(4);

        // R6/R5: release of minimum level, exact delay including line readback
        vmin_below = 1'b0;
        tick(POR + 3);
        chk("R6 held until boundary", 8'(cpu_rst), 8'd1);
        tick(1);
        chk("R6 released at boundary", 8'(cpu_rst), 8'd0);

        // R7: restart when cause returns mid-count
        vmin_below = 1'b1;
        tick(5);
        vmin_below = 1'b0;
        tick(10);
        vmin_below = 1'b1;
        tick(3);
        vmin_below = 1'b0;
        tick(POR + 3);
        chk("R7 restarted count held", 8'(cpu_rst), 8'd1);
        tick(1);
        chk("R7 released after full delay", 8'(cpu_rst), 8'd0);

        // R5: external pull on the line
        ext_pull = 1'b1;
        tick(2);
        chk("R5 not yet", 8'(cpu_rst), 8'd0);
        tick(1);
        chk("R5 external forces reset", 8'(cpu_rst), 8'd1);
        chk("R5 not driven by block", 8'(rst_pin_oe), 8'd0);
        ext_pull = 1'b0;
        tick(POR + 1);
        chk("R5/R6 held after ext release", 8'(cpu_rst), 8'd1);
        tick(1);
        chk("R5/R6 released after ext", 8'(cpu_rst), 8'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule